// File: doc/BRIEF.md
# Periodic SPI Poller with Idle-Byte Filter

This block is an SPI master that reads one byte from a streaming sensor at a fixed rate, with no software involved. An internal timer starts each read. The block drives chip select itself, with a programmable lead time before the first clock edge and a programmable lag after the last one. It also sets the serial clock rate, which comes from a divider of the system clock.

Each received byte is checked. A slave with nothing to report returns the filler value 0xFF, and the block drops such bytes silently. Any other byte is latched into a single result register and raises a sticky level interrupt. If a second useful byte arrives before software has cleared the interrupt, an overrun flag is set and the newer byte replaces the older one. The received line is forced to 1 whenever chip select is high, so a line that floats or sits low between frames cannot look like data.

Under the timing rules below, a 125 MHz system clock gives a poll rate of 125 kHz with `poll_period` = 1000. With `sck_div` = 12 the serial clock runs at 5.2 MHz.

Top module: `spi_idle_poller`

## Requirements
- R1: While `enable` is high, a new read starts (`spi_cs_n` falls) every `poll_period` clock cycles. A value of 0 acts as 1.
- R2: The SPI bus uses mode 0. `spi_sck` is low whenever `spi_cs_n` is high, each SCK high phase lasts `sck_div` cycles (minimum 1), and each read has exactly 8 rising edges.
- R3: `spi_miso` is sampled at each rising SCK edge, most significant bit first. A kept byte appears on `data_out` and is held until the next kept byte arrives.
- R4: During a read, `spi_mosi` carries 0xFF, most significant bit first, and is valid at every rising SCK edge.
- R5: The first rising SCK edge comes `cs_setup` clock cycles after `spi_cs_n` falls. Values below 2 act as 2.
- R6: `spi_cs_n` rises `cs_hold` clock cycles after the last falling SCK edge. A value of 0 acts as 1.
- R7: A received byte of 0xFF leaves `irq`, `overrun` and `data_out` unchanged.
- R8: A received byte other than 0xFF sets `irq` one cycle after `spi_cs_n` rises. `irq` stays high until a cycle in which `irq_clr` is high.
- R9: A kept byte that arrives while `irq` is pending and not being cleared sets `overrun`, and `data_out` takes the newer byte. `irq_clr` clears both `irq` and `overrun`.
- R10: A poll tick that falls while a read is in progress is dropped. For a read with `spi_cs_n` low for D cycles, consecutive reads therefore start (D / `poll_period` + 1) × `poll_period` cycles apart, using integer division.
- R11: Clearing `enable` during a read lets that read finish at full length and capture its byte. No further read starts until `enable` is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the poll timer |
| poll_period | input | 16 | Clock cycles between read starts |
| sck_div | input | 8 | SCK half period in clock cycles |
| cs_setup | input | 8 | Cycles from CS fall to the first SCK rise |
| cs_hold | input | 8 | Cycles from the last SCK fall to CS rise |
| irq_clr | input | 1 | Clears the interrupt and the overrun flag |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_cs_n | output | 1 | Active-low chip select |
| data_out | output | 8 | Last kept byte |
| irq | output | 1 | Sticky interrupt level |
| overrun | output | 1 | A kept byte replaced one still pending |

## Verification
Suppose the engine's edge or bit counter is off by one. Within the very first read this shows as a setup time, hold time, high-phase length or rising-edge count that differs from the configured value. It also shows as a corrupted byte at the next interrupt.

A filter fault shows within one read: either an interrupt on a 0xFF byte, or a missing interrupt and a stale `data_out`. A timer fault that wrongly queues or drops ticks appears at the second read start, as a spacing different from `poll_period` or from the rounded-up multiple predicted for long reads.

// File: rtl/spip_pkg.sv
package spip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } eng_state_t;

  // Clamp a programmed count to a floor value.
  function automatic logic [31:0] floor_at(input logic [31:0] val, input logic [31:0] lo);
    return (val < lo) ? lo : val;
  endfunction

  // True when a counter started at zero has spent "need" cycles,
  // given that "spent_extra" cycles are already used up elsewhere.
  function automatic logic count_reached(input logic [31:0] cnt, input logic [31:0] spent_extra,
                                         input logic [31:0] need);
    return (cnt + spent_extra) >= need;
  endfunction

endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  import spip_pkg::*;

  logic [PERIOD_W-1:0] cnt;
  logic [31:0]         period_eff;

  assign period_eff = floor_at(32'(period), 32'd1);
  assign tick       = en && (32'(cnt) == period_eff - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int                DIV_W   = 8,
  parameter int                GAP_W   = 8,
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] TX_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  sck_div,
  input  logic [GAP_W-1:0]  cs_setup,
  input  logic [GAP_W-1:0]  cs_hold,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte
);
  import spip_pkg::*;

  localparam int BIT_W = $clog2(DATA_W + 1);

  eng_state_t        state;
  logic [GAP_W-1:0]  gap_cnt;
  logic [DIV_W-1:0]  half_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;

  logic [31:0] div_eff, setup_eff, hold_eff;
  logic        miso_in;
  logic        half_end;
  logic        sck_rise_evt, sck_fall_evt, last_fall_evt;
  logic        setup_done, hold_done;

  assign div_eff   = floor_at(32'(sck_div), 32'd1);
  assign setup_eff = floor_at(32'(cs_setup), 32'd2);
  assign hold_eff  = floor_at(32'(cs_hold), 32'd1);

  // Line is pulled to 1 while deselected.
  assign miso_in = cs_n ? 1'b1 : miso;

  assign half_end      = (32'(half_cnt) == div_eff - 32'd1);
  assign sck_rise_evt  = (state == ST_SHIFT) && half_end && !sck;
  assign sck_fall_evt  = (state == ST_SHIFT) && half_end && sck;
  assign last_fall_evt = sck_fall_evt && (bit_cnt == BIT_W'(DATA_W));
  // Two cycles of setup are spent entering and leaving SETUP.
  assign setup_done    = (state == ST_SETUP) && count_reached(32'(gap_cnt), 32'd2, setup_eff);
  assign hold_done     = (state == ST_HOLD) && count_reached(32'(gap_cnt), 32'd1, hold_eff);

  assign mosi = tx_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cs_n     <= 1'b1;
      sck      <= 1'b0;
      gap_cnt  <= '0;
      half_cnt <= '0;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= TX_WORD;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
    end else begin
      rx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cs_n    <= 1'b0;
            gap_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= TX_WORD;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (setup_done) begin
            half_cnt <= DIV_W'(div_eff - 32'd1);
            state    <= ST_SHIFT;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!half_end) begin
            half_cnt <= half_cnt + 1'b1;
          end else begin
            half_cnt <= '0;
            sck      <= !sck;
            if (sck_rise_evt) begin
              rx_sr   <= {rx_sr[DATA_W-2:0], miso_in};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (last_fall_evt) begin
              gap_cnt <= '0;
              state   <= ST_HOLD;
            end else begin
              tx_sr <= {tx_sr[DATA_W-2:0], 1'b1};
            end
          end
        end
        ST_HOLD: begin
          if (hold_done) begin
            cs_n     <= 1'b1;
            rx_valid <= 1'b1;
            rx_byte  <= rx_sr;
            state    <= ST_IDLE;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/result_filter.sv
module result_filter #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              irq_clr,
  output logic              accept,
  output logic [DATA_W-1:0] data_out,
  output logic              irq,
  output logic              overrun
);
  logic pending_kept;

  assign accept       = rx_valid && (rx_byte != IDLE_VAL);
  assign pending_kept = irq && !irq_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out <= '0;
      irq      <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (accept) begin
        data_out <= rx_byte;
      end
      irq     <= accept || pending_kept;
      overrun <= (accept && pending_kept) || (overrun && !irq_clr);
    end
  end
endmodule

// File: rtl/spi_idle_poller.sv
module spi_idle_poller #(
  parameter int                PERIOD_W = 16,
  parameter int                DIV_W    = 8,
  parameter int                GAP_W    = 8,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] IDLE_VAL = '1,
  parameter logic [DATA_W-1:0] TX_WORD  = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] poll_period,
  input  logic [DIV_W-1:0]    sck_div,
  input  logic [GAP_W-1:0]    cs_setup,
  input  logic [GAP_W-1:0]    cs_hold,
  input  logic                irq_clr,
  output logic                spi_sck,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic                spi_cs_n,
  output logic [DATA_W-1:0]   data_out,
  output logic                irq,
  output logic                overrun
);
  logic              poll_tick;
  logic              rx_valid;
  logic [DATA_W-1:0] rx_byte;
  logic              accept;

  poll_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (enable),
    .period (poll_period),
    .tick   (poll_tick)
  );

  spi_byte_engine #(
    .DIV_W   (DIV_W),
    .GAP_W   (GAP_W),
    .DATA_W  (DATA_W),
    .TX_WORD (TX_WORD)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (poll_tick),
    .sck_div  (sck_div),
    .cs_setup (cs_setup),
    .cs_hold  (cs_hold),
    .miso     (spi_miso),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .cs_n     (spi_cs_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte)
  );

  result_filter #(
    .DATA_W   (DATA_W),
    .IDLE_VAL (IDLE_VAL)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .irq_clr  (irq_clr),
    .accept   (accept),
    .data_out (data_out),
    .irq      (irq),
    .overrun  (overrun)
  );
endmodule

// File: rtl/spi_idle_poller_chk.sv
module spi_idle_poller_chk #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_sck,
  input logic              irq,
  input logic              irq_clr,
  input logic              overrun,
  input logic [DATA_W-1:0] data_out,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_byte,
  input logic              accept
);
  assert_sck_low_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_overrun_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> irq);

  assert_filler_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_byte == IDLE_VAL && !irq) |=> !irq);

  assert_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(data_out));

  assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !rx_valid) |=> (!irq && !overrun));
endmodule

bind spi_idle_poller spi_idle_poller_chk #(.DATA_W(DATA_W), .IDLE_VAL(IDLE_VAL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spi_cs_n (spi_cs_n),
  .spi_sck  (spi_sck),
  .irq      (irq),
  .irq_clr  (irq_clr),
  .overrun  (overrun),
  .data_out (data_out),
  .rx_valid (rx_valid),
  .rx_byte  (rx_byte),
  .accept   (accept)
);

// File: tb/sim_spi_idle_poller.sv
`timescale 1ns/1ps
module sim_spi_idle_poller;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] poll_period = 16'd200;
  logic [7:0]  sck_div = 8'd3;
  logic [7:0]  cs_setup = 8'd4;
  logic [7:0]  cs_hold = 8'd2;
  logic        mon_clr = 1'b0;
  logic        tb_clr = 1'b0;
  logic        irq_clr;
  logic        spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;
  logic [7:0]  data_out;
  logic        irq, overrun;

  assign irq_clr = mon_clr | tb_clr;

  always #4 clk = ~clk;

  spi_idle_poller u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .poll_period(poll_period),
    .sck_div(sck_div), .cs_setup(cs_setup), .cs_hold(cs_hold), .irq_clr(irq_clr),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
    .data_out(data_out), .irq(irq), .overrun(overrun)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] slave_byte = 8'hFF;
  logic [7:0] last_good = 8'h00;
  logic       mon_en = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // Port meter and slave model, sampled between clock edges.
  logic prev_cs = 1'b1, prev_sck = 1'b0;
  int cs_fall = 0, prev_fall = 0, cs_rise = 0, first_rise = 0, last_rise = 0;
  int last_fall = 0, high_time = 0, nrise = 0, n_falls = 0;
  logic [7:0] mosi_cap = 8'h00, slave_sr = 8'hFF;

  always @(negedge clk) begin
    if (prev_cs && !spi_cs_n) begin
      prev_fall <= cs_fall;
      cs_fall   <= cyc;
      nrise     <= 0;
      n_falls   <= n_falls + 1;
      slave_sr  <= slave_byte;
      spi_miso  <= slave_byte[7];
    end
    if (!prev_sck && spi_sck) begin
      if (nrise == 0) first_rise <= cyc;
      nrise     <= nrise + 1;
      mosi_cap  <= {mosi_cap[6:0], spi_mosi};
      last_rise <= cyc;
    end
    if (prev_sck && !spi_sck) begin
      last_fall <= cyc;
      high_time <= cyc - last_rise;
      slave_sr  <= {slave_sr[6:0], 1'b1};
      spi_miso  <= slave_sr[6];
    end
    if (!prev_cs && spi_cs_n) begin
      cs_rise  <= cyc;
      spi_miso <= 1'b0;
    end
    prev_cs  <= spi_cs_n;
    prev_sck <= spi_sck;
  end

  // Scoreboard monitor: every interrupt must match the next expected byte.
  logic prev_irq = 1'b0;
  always @(negedge clk) begin
    mon_clr  <= 1'b0;
    prev_irq <= irq;
    if (rst_n && mon_en && irq && !mon_clr) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected irq", int'(data_out), -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(data_out == e, "R3 data_out", int'(data_out), int'(e));
        if (!prev_irq) chk(cyc - cs_rise == 1, "R8 irq delay", cyc - cs_rise, 1);
        last_good = e;
      end
      mon_clr <= 1'b1;
    end
  end

  task automatic run_poll(input logic [7:0] b);
    int d_setup, d_hold;
    d_setup = (cs_setup < 2) ? 2 : int'(cs_setup);
    d_hold  = (cs_hold < 1) ? 1 : int'(cs_hold);
    slave_byte = b;
    if (b != 8'hFF) exp_q.push_back(b);
    @(negedge spi_cs_n);
    @(posedge spi_cs_n);
    repeat (3) @(negedge clk);
    chk(nrise == 8, "R2 rising edges", nrise, 8);
    chk(high_time == int'(sck_div), "R2 high phase", high_time, int'(sck_div));
    chk(mosi_cap == 8'hFF, "R4 mosi", int'(mosi_cap), 255);
    chk(first_rise - cs_fall == d_setup, "R5 setup", first_rise - cs_fall, d_setup);
    chk(cs_rise - last_fall == d_hold, "R6 hold", cs_rise - last_fall, d_hold);
    if (b == 8'hFF) begin
      chk(!irq && data_out == last_good, "R7 filler ignored", int'(data_out), int'(last_good));
    end
  endtask

  initial begin
    int falls_before;
    int d;
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !irq && !overrun && data_out == 8'h00,
        "reset state", int'(data_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    enable = 1'b1;

    run_poll(8'hFF);
    run_poll(8'h3C);
    chk(cs_fall - prev_fall == 200, "R1 poll spacing", cs_fall - prev_fall, 200);
    run_poll(8'hA5);
    run_poll(8'hFF);
    run_poll(8'h00);
    run_poll(8'h7F);
    chk(cs_fall - prev_fall == 200, "R1 poll spacing again", cs_fall - prev_fall, 200);

    // R11: disable mid-read, read completes, no more reads.
    slave_byte = 8'h5A;
    exp_q.push_back(8'h5A);
    @(negedge spi_cs_n);
    @(negedge clk);
    enable = 1'b0;
    @(posedge spi_cs_n);
    repeat (3) @(negedge clk);
    d = 4 + 15 * 3 + 2;
    chk(cs_rise - cs_fall == d, "R11 full read after disable", cs_rise - cs_fall, d);
    chk(data_out == 8'h5A, "R11 byte captured", int'(data_out), 90);
    falls_before = n_falls;
    repeat (600) @(negedge clk);
    chk(n_falls == falls_before, "R11 no read while disabled", n_falls, falls_before);

    // R10: period shorter than a read.
    poll_period = 16'd20;
    sck_div     = 8'd2;
    cs_setup    = 8'd3;
    cs_hold     = 8'd2;
    enable      = 1'b1;
    run_poll(8'hFF);
    run_poll(8'hFF);
    d = 3 + 15 * 2 + 2;
    chk(cs_fall - prev_fall == (d / 20 + 1) * 20, "R10 dropped ticks",
        cs_fall - prev_fall, (d / 20 + 1) * 20);

    // R9: overrun with the monitor parked.
    mon_en = 1'b0;
    @(posedge spi_cs_n);
    slave_byte = 8'h11;
    @(posedge spi_cs_n);
    slave_byte = 8'h22;
    repeat (2) @(negedge clk);
    chk(irq && !overrun && data_out == 8'h11, "R8 first kept byte", int'(data_out), 17);
    @(posedge spi_cs_n);
    slave_byte = 8'hFF;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
    chk(data_out == 8'h22, "R9 newest kept", int'(data_out), 34);
    repeat (50) @(negedge clk);
    chk(irq == 1'b1, "R8 irq sticky", int'(irq), 1);
    tb_clr = 1'b1;
    @(negedge clk);
    tb_clr = 1'b0;
    @(negedge clk);
    chk(!irq && !overrun, "R9 clear", int'({irq, overrun}), 0);
    last_good = 8'h22;
    mon_en = 1'b1;

    // R7 again after overrun: filler leaves state alone.
    enable = 1'b1;
    run_poll(8'hFF);
    enable = 1'b0;
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule